// File: doc/BRIEF.md
# CHS Sector Address Sequencer

This block holds the running disk address of a sector transfer and turns it into a linear sector number. The address can be a cylinder/head/sector triple or, in linear mode, a plain sector index. In cylinder/head/sector mode the conversion uses a translated geometry, which is a head count and a sectors-per-track value. An initialize-parameters request sets that geometry. A hard reset puts the drive's native geometry back.

A controller loads the starting address and pulses `step` once for each sector moved. It reads `lin_addr` whenever `addr_ready` is high. The multiply-add runs in two registered stages, so the result always arrives a fixed number of cycles after any event that changes it. A DMA request is checked against the geometry-valid flag. If no geometry has been programmed since the last hard reset, the request ends with an ID-not-found indication.

Top module: `chs_addr_seq`

## Requirements
- R1: While `hard_rst` is high and for one cycle after the last reset edge, `addr_ready` is 0. In the second cycle after that edge it is 1, `lin_addr` is 0 (address C0/H0/S1) and `geo_valid` is 0.
- R2: In cylinder/head/sector mode `lin_addr` = ((cyl × heads) + head) × spt + (sect − 1), computed with the translated heads and spt.
- R3: A step with sector below spt increments the sector. A step with sector equal to spt sets the sector to 1 and increments the head.
- R4: When the head would reach the translated head count it returns to 0 and the cylinder increments. The cylinder wraps modulo 2^CYL_W.
- R5: `geo_set` makes spt equal to `geo_cnt` and heads equal to `geo_hfld` + 1, and sets `geo_valid` to 1.
- R6: A `geo_cnt` of 0 sets spt to 2^CNT_W (256 by default).
- R7: With `lba_mode` = 1, a load takes `ld_lba`, a step adds 1 modulo 2^LBA_W, and `lin_addr` is that value. The cylinder/head/sector fields are neither loaded nor stepped and are unchanged on return to mode 0.
- R8: After `load`, `step`, `geo_set` or a change of `lba_mode` is sampled at edge k, `addr_ready` is 0 after edges k and k+1. After edge k+2 it is 1 with the new `lin_addr`. Otherwise `addr_ready` and `lin_addr` hold.
- R9: A `dma_req` sampled at edge k gives a one-cycle pulse after edge k. The pulse is on `dma_idnf` when the geometry is not valid and on `dma_start` when it is valid. Without a request both outputs are 0.
- R10: A hard reset copies `nat_heads` and `nat_spt` into the translated geometry and clears `geo_valid`. `geo_valid` otherwise stays 1 once set.
- R11: When `load` and `step` are both high in one cycle, the load wins and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| nat_heads | input | HD_W | Native head count |
| nat_spt | input | CNT_W+1 | Native sectors per track |
| load | input | 1 | Load the starting address |
| ld_cyl | input | CYL_W | Starting cylinder |
| ld_head | input | HD_W | Starting head |
| ld_sect | input | CNT_W+1 | Starting sector (1-based) |
| ld_lba | input | LBA_W | Starting linear address, used in linear mode |
| step | input | 1 | Advance by one sector |
| lba_mode | input | 1 | 1 selects linear addressing |
| geo_set | input | 1 | Initialize-parameters request |
| geo_cnt | input | CNT_W | Sectors per track for the request, 0 means 2^CNT_W |
| geo_hfld | input | HFLD_W | Head field, head count is this plus 1 |
| dma_req | input | 1 | DMA read or write issued |
| lin_addr | output | LBA_W | Linear sector number |
| addr_ready | output | 1 | `lin_addr` is current |
| geo_valid | output | 1 | Translated geometry programmed since hard reset |
| dma_start | output | 1 | DMA accepted pulse |
| dma_idnf | output | 1 | DMA rejected with ID-not-found pulse |

## Verification
The bench builds the block with a 4-bit cylinder field and a 12-bit linear address. Both the cylinder wrap and the linear-address wrap then take one step from a loaded value. At this size every expected product also fits the output without truncation, so each cylinder/head/sector result can be compared exactly. Head and sector-count widths stay at their defaults, which keeps the 256-sector case of a zero count and the full 4-bit head field in reach.

// File: rtl/chs_seq_pkg.sv
package chs_seq_pkg;
    localparam int unsigned LIN_LAT = 2;

    typedef enum logic [1:0] {
        DMA_IDLE = 2'b00,
        DMA_GO   = 2'b01,
        DMA_IDNF = 2'b10
    } dma_res_e;
endpackage

// File: rtl/chs_geom.sv
module chs_geom
    import chs_seq_pkg::*;
#(
    parameter int HD_W   = 8,
    parameter int CNT_W  = 8,
    parameter int HFLD_W = 4,
    parameter int SPT_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              hard_rst,
    input  logic [HD_W-1:0]   nat_heads,
    input  logic [SPT_W-1:0]  nat_spt,
    input  logic              geo_set,
    input  logic [CNT_W-1:0]  geo_cnt,
    input  logic [HFLD_W-1:0] geo_hfld,
    input  logic              dma_req,
    output logic [HD_W-1:0]   t_heads,
    output logic [SPT_W-1:0]  t_spt,
    output logic              valid,
    output dma_res_e          dma_res
);
    typedef struct packed {
        logic [HD_W-1:0]  heads;
        logic [SPT_W-1:0] spt;
        logic             ok;
        dma_res_e         dma;
    } geo_t;

    geo_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.dma = DMA_IDLE;
        if (dma_req)
            g_d.dma = g_q.ok ? DMA_GO : DMA_IDNF;
        if (geo_set) begin
            g_d.spt   = (geo_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : SPT_W'(geo_cnt);
            g_d.heads = HD_W'(geo_hfld) + HD_W'(1);
            g_d.ok    = 1'b1;
        end
        if (hard_rst) begin
            g_d.heads = nat_heads;
            g_d.spt   = nat_spt;
            g_d.ok    = 1'b0;
            g_d.dma   = DMA_IDLE;
        end
    end

    always_ff @(posedge clk) g_q <= g_d;

    assign t_heads = g_q.heads;
    assign t_spt   = g_q.spt;
    assign valid   = g_q.ok;
    assign dma_res = g_q.dma;
endmodule

// File: rtl/chs_step.sv
module chs_step #(
    parameter int CYL_W = 16,
    parameter int HD_W  = 8,
    parameter int SPT_W = 9,
    parameter int LBA_W = 28
) (
    input  logic             clk,
    input  logic             hard_rst,
    input  logic             load,
    input  logic             step,
    input  logic             lba_mode,
    input  logic [CYL_W-1:0] ld_cyl,
    input  logic [HD_W-1:0]  ld_head,
    input  logic [SPT_W-1:0] ld_sect,
    input  logic [LBA_W-1:0] ld_lba,
    input  logic [HD_W-1:0]  t_heads,
    input  logic [SPT_W-1:0] t_spt,
    output logic [CYL_W-1:0] cyl,
    output logic [HD_W-1:0]  head,
    output logic [SPT_W-1:0] sect,
    output logic [LBA_W-1:0] lba
);
    typedef struct packed {
        logic [CYL_W-1:0] cyl;
        logic [HD_W-1:0]  head;
        logic [SPT_W-1:0] sect;
        logic [LBA_W-1:0] lba;
    } pos_t;

    pos_t p_d, p_q;
    logic [HD_W-1:0] head_nx;

    always_comb begin
        p_d     = p_q;
        head_nx = p_q.head + HD_W'(1);
        if (load) begin
            if (lba_mode) begin
                p_d.lba = ld_lba;
            end else begin
                p_d.cyl  = ld_cyl;
                p_d.head = ld_head;
                p_d.sect = ld_sect;
            end
        end else if (step) begin
            if (lba_mode) begin
                p_d.lba = p_q.lba + LBA_W'(1);
            end else if (p_q.sect >= t_spt) begin
                p_d.sect = SPT_W'(1);
                if (head_nx >= t_heads) begin
                    p_d.head = '0;
                    p_d.cyl  = p_q.cyl + CYL_W'(1);
                end else begin
                    p_d.head = head_nx;
                end
            end else begin
                p_d.sect = p_q.sect + SPT_W'(1);
            end
        end
        if (hard_rst) begin
            p_d.cyl  = '0;
            p_d.head = '0;
            p_d.sect = SPT_W'(1);
            p_d.lba  = '0;
        end
    end

    always_ff @(posedge clk) p_q <= p_d;

    assign cyl  = p_q.cyl;
    assign head = p_q.head;
    assign sect = p_q.sect;
    assign lba  = p_q.lba;
endmodule

// File: rtl/chs_lin.sv
module chs_lin #(
    parameter int CYL_W = 16,
    parameter int HD_W  = 8,
    parameter int SPT_W = 9,
    parameter int LBA_W = 28
) (
    input  logic             clk,
    input  logic             hard_rst,
    input  logic             kick,
    input  logic             lba_mode,
    input  logic [CYL_W-1:0] cyl,
    input  logic [HD_W-1:0]  head,
    input  logic [SPT_W-1:0] sect,
    input  logic [LBA_W-1:0] lba,
    input  logic [HD_W-1:0]  t_heads,
    input  logic [SPT_W-1:0] t_spt,
    output logic [LBA_W-1:0] lin,
    output logic             ready
);
    localparam int S1_W   = CYL_W + HD_W;
    localparam int FULL_W = S1_W + SPT_W;

    typedef struct packed {
        logic             mode;
        logic             st0;
        logic             st1;
        logic             rdy;
        logic [S1_W-1:0]  s1;
        logic [LBA_W-1:0] lin;
    } pipe_t;

    pipe_t r_d, r_q;
    logic              restart;
    logic [FULL_W-1:0] full;

    always_comb begin
        r_d     = r_q;
        restart = kick | (lba_mode != r_q.mode);
        full    = FULL_W'(r_q.s1) * FULL_W'(t_spt) + FULL_W'(sect) - FULL_W'(1);
        r_d.mode = lba_mode;
        r_d.st0  = restart;
        r_d.st1  = r_q.st0 & ~restart;
        if (r_q.st0)
            r_d.s1 = S1_W'(cyl) * S1_W'(t_heads) + S1_W'(head);
        if (r_q.st1 & ~restart) begin
            r_d.lin = r_q.mode ? lba : LBA_W'(full);
            r_d.rdy = 1'b1;
        end
        if (restart)
            r_d.rdy = 1'b0;
        if (hard_rst) begin
            r_d.mode = lba_mode;
            r_d.st0  = 1'b1;
            r_d.st1  = 1'b0;
            r_d.rdy  = 1'b0;
            r_d.s1   = '0;
            r_d.lin  = '0;
        end
    end

    always_ff @(posedge clk) r_q <= r_d;

    assign lin   = r_q.lin;
    assign ready = r_q.rdy;
endmodule

// File: rtl/chs_addr_seq.sv
module chs_addr_seq
    import chs_seq_pkg::*;
#(
    parameter int CYL_W  = 16,
    parameter int HD_W   = 8,
    parameter int CNT_W  = 8,
    parameter int HFLD_W = 4,
    parameter int LBA_W  = 28
) (
    input  logic                clk,
    input  logic                hard_rst,
    input  logic [HD_W-1:0]     nat_heads,
    input  logic [CNT_W:0]      nat_spt,
    input  logic                load,
    input  logic [CYL_W-1:0]    ld_cyl,
    input  logic [HD_W-1:0]     ld_head,
    input  logic [CNT_W:0]      ld_sect,
    input  logic [LBA_W-1:0]    ld_lba,
    input  logic                step,
    input  logic                lba_mode,
    input  logic                geo_set,
    input  logic [CNT_W-1:0]    geo_cnt,
    input  logic [HFLD_W-1:0]   geo_hfld,
    input  logic                dma_req,
    output logic [LBA_W-1:0]    lin_addr,
    output logic                addr_ready,
    output logic                geo_valid,
    output logic                dma_start,
    output logic                dma_idnf
);
    localparam int SPT_W = CNT_W + 1;

    logic [HD_W-1:0]  t_heads;
    logic [SPT_W-1:0] t_spt;
    logic [CYL_W-1:0] cyl;
    logic [HD_W-1:0]  head;
    logic [SPT_W-1:0] sect;
    logic [LBA_W-1:0] lba;
    dma_res_e         dma_res;

    chs_geom #(.HD_W(HD_W), .CNT_W(CNT_W), .HFLD_W(HFLD_W), .SPT_W(SPT_W)) u_geom (
        .clk(clk), .hard_rst(hard_rst), .nat_heads(nat_heads), .nat_spt(nat_spt),
        .geo_set(geo_set), .geo_cnt(geo_cnt), .geo_hfld(geo_hfld), .dma_req(dma_req),
        .t_heads(t_heads), .t_spt(t_spt), .valid(geo_valid), .dma_res(dma_res)
    );

    chs_step #(.CYL_W(CYL_W), .HD_W(HD_W), .SPT_W(SPT_W), .LBA_W(LBA_W)) u_step (
        .clk(clk), .hard_rst(hard_rst), .load(load), .step(step), .lba_mode(lba_mode),
        .ld_cyl(ld_cyl), .ld_head(ld_head), .ld_sect(ld_sect), .ld_lba(ld_lba),
        .t_heads(t_heads), .t_spt(t_spt),
        .cyl(cyl), .head(head), .sect(sect), .lba(lba)
    );

    chs_lin #(.CYL_W(CYL_W), .HD_W(HD_W), .SPT_W(SPT_W), .LBA_W(LBA_W)) u_lin (
        .clk(clk), .hard_rst(hard_rst), .kick(load | step | geo_set), .lba_mode(lba_mode),
        .cyl(cyl), .head(head), .sect(sect), .lba(lba),
        .t_heads(t_heads), .t_spt(t_spt), .lin(lin_addr), .ready(addr_ready)
    );

    assign dma_start = (dma_res == DMA_GO);
    assign dma_idnf  = (dma_res == DMA_IDNF);
endmodule

// File: rtl/chs_addr_seq_chk.sv
module chs_addr_seq_chk #(
    parameter int LBA_W = 28
) (
    input logic             clk,
    input logic             hard_rst,
    input logic             load,
    input logic             step,
    input logic             lba_mode,
    input logic             geo_set,
    input logic             dma_req,
    input logic [LBA_W-1:0] lin_addr,
    input logic             addr_ready,
    input logic             geo_valid,
    input logic             dma_start,
    input logic             dma_idnf
);
    p_kick_unready_r8: assert property (@(posedge clk) disable iff (hard_rst)
        (load || step || geo_set) |=> !addr_ready);

    p_hold_r2: assert property (@(posedge clk) disable iff (hard_rst)
        (addr_ready && !load && !step && !geo_set && $stable(lba_mode))
        |=> (addr_ready && $stable(lin_addr)));

    p_geo_set_r5: assert property (@(posedge clk) disable iff (hard_rst)
        geo_set |=> geo_valid);

    p_valid_keep_r10: assert property (@(posedge clk) disable iff (hard_rst)
        geo_valid |=> geo_valid);

    p_dma_idnf_r9: assert property (@(posedge clk) disable iff (hard_rst)
        (dma_req && !geo_valid) |=> (dma_idnf && !dma_start));

    p_dma_go_r9: assert property (@(posedge clk) disable iff (hard_rst)
        (dma_req && geo_valid) |=> (dma_start && !dma_idnf));

    p_dma_quiet_r9: assert property (@(posedge clk) disable iff (hard_rst)
        !dma_req |=> (!dma_start && !dma_idnf));
endmodule

bind chs_addr_seq chs_addr_seq_chk #(.LBA_W(LBA_W)) u_chk (
    .clk(clk), .hard_rst(hard_rst), .load(load), .step(step), .lba_mode(lba_mode),
    .geo_set(geo_set), .dma_req(dma_req), .lin_addr(lin_addr), .addr_ready(addr_ready),
    .geo_valid(geo_valid), .dma_start(dma_start), .dma_idnf(dma_idnf)
);

// File: tb/chs_addr_seq_bench.sv
module chs_addr_seq_bench;
    localparam int CYL_W = 4, HD_W = 8, CNT_W = 8, HFLD_W = 4, LBA_W = 12;

    logic clk = 1'b0;
    logic hard_rst = 1'b1;
    logic [HD_W-1:0] nat_heads = 8'd4;
    logic [CNT_W:0] nat_spt = 9'd17;
    logic load = 0, step = 0, lba_mode = 0, geo_set = 0, dma_req = 0;
    logic [CYL_W-1:0] ld_cyl = '0;
    logic [HD_W-1:0] ld_head = '0;
    logic [CNT_W:0] ld_sect = 9'd1;
    logic [LBA_W-1:0] ld_lba = '0;
    logic [CNT_W-1:0] geo_cnt = '0;
    logic [HFLD_W-1:0] geo_hfld = '0;
    logic [LBA_W-1:0] lin_addr;
    logic addr_ready, geo_valid, dma_start, dma_idnf;

    int errs = 0, checks = 0;
    int mc, mh, ms, mH, mS, mlba;

    chs_addr_seq #(.CYL_W(CYL_W), .HD_W(HD_W), .CNT_W(CNT_W), .HFLD_W(HFLD_W), .LBA_W(LBA_W))
    u_chs_addr_seq (
        .clk(clk), .hard_rst(hard_rst), .nat_heads(nat_heads), .nat_spt(nat_spt),
        .load(load), .ld_cyl(ld_cyl), .ld_head(ld_head), .ld_sect(ld_sect), .ld_lba(ld_lba),
        .step(step), .lba_mode(lba_mode), .geo_set(geo_set), .geo_cnt(geo_cnt),
        .geo_hfld(geo_hfld), .dma_req(dma_req), .lin_addr(lin_addr), .addr_ready(addr_ready),
        .geo_valid(geo_valid), .dma_start(dma_start), .dma_idnf(dma_idnf)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int chs_lin();
        return ((mc * mH) + mh) * mS + ms - 1;
    endfunction

    // strobes were set at a negedge; follow the two pipeline stages
    task automatic settle(string req, int exp);
        @(negedge clk);
        load = 0; step = 0; geo_set = 0; dma_req = 0;
        chk("R8", {req, " ready low 1"}, int'(addr_ready), 0);
        @(negedge clk);
        chk("R8", {req, " ready low 2"}, int'(addr_ready), 0);
        @(negedge clk);
        chk("R8", {req, " ready high"}, int'(addr_ready), 1);
        chk(req, "lin_addr", int'(lin_addr), exp);
    endtask

    task automatic do_load(string req, int c, int h, int s, int l);
        @(negedge clk);
        load = 1; ld_cyl = CYL_W'(c); ld_head = HD_W'(h); ld_sect = (CNT_W+1)'(s); ld_lba = LBA_W'(l);
        if (lba_mode) mlba = l; else begin mc = c; mh = h; ms = s; end
        settle(req, lba_mode ? mlba : chs_lin());
    endtask

    task automatic do_step(string req);
        @(negedge clk);
        step = 1;
        if (lba_mode) mlba = (mlba + 1) % (1 << LBA_W);
        else if (ms >= mS) begin
            ms = 1;
            if (mh + 1 >= mH) begin mh = 0; mc = (mc + 1) % (1 << CYL_W); end
            else mh = mh + 1;
        end else ms = ms + 1;
        settle(req, lba_mode ? mlba : chs_lin());
    endtask

    task automatic do_dma(string req, int idnf);
        @(negedge clk);
        dma_req = 1;
        @(negedge clk);
        dma_req = 0;
        chk(req, "dma_idnf", int'(dma_idnf), idnf);
        chk(req, "dma_start", int'(dma_start), 1 - idnf);
        @(negedge clk);
        chk(req, "dma pulse over", int'(dma_idnf | dma_start), 0);
    endtask

    task automatic t_reset(string req);
        @(negedge clk);
        hard_rst = 1;
        repeat (3) @(negedge clk);
        hard_rst = 0;
        mc = 0; mh = 0; ms = 1; mlba = 0; mH = nat_heads; mS = nat_spt;
        @(negedge clk);
        chk(req, "ready low after reset", int'(addr_ready), 0);
        @(negedge clk);
        chk(req, "ready after reset", int'(addr_ready), 1);
        chk(req, "lin after reset", int'(lin_addr), 0);
        chk(req, "geo_valid after reset", int'(geo_valid), 0);
    endtask

    task automatic t_geo(string req, int cnt, int hf);
        @(negedge clk);
        geo_set = 1; geo_cnt = CNT_W'(cnt); geo_hfld = HFLD_W'(hf);
        mS = (cnt == 0) ? 256 : cnt; mH = hf + 1;
        settle(req, chs_lin());
        chk(req, "geo_valid set", int'(geo_valid), 1);
    endtask

    task automatic t_prio();
        @(negedge clk);
        load = 1; step = 1; ld_cyl = 0; ld_head = 0; ld_sect = 9'd5;
        mc = 0; mh = 0; ms = 5;
        settle("R11", chs_lin());
    endtask

    task automatic t_mode(string req, bit m);
        @(negedge clk);
        lba_mode = m;
        settle(req, m ? mlba : chs_lin());
    endtask

    initial begin
        #1_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset("R1");
        do_dma("R9", 1);
        do_load("R2", 3, 2, 5, 0);          // (12+2)*17+4 = 242
        do_load("R2", 0, 3, 17, 0);         // 67
        t_geo("R5", 10, 5);                  // heads 6, spt 10
        do_dma("R9", 0);
        do_load("R2", 1, 4, 9, 0);
        do_step("R3");                       // sect 10
        do_step("R3");                       // head 5, sect 1
        do_load("R4", 1, 5, 10, 0);
        do_step("R4");                       // cyl 2, head 0 -> 120
        do_load("R4", 15, 5, 10, 0);
        do_step("R4");                       // cyl wraps to 0 -> 0
        t_geo("R6", 0, 0);                   // spt 256, heads 1
        do_load("R6", 0, 0, 255, 0);
        do_step("R6");                       // sect 256 -> 255
        do_step("R6");                       // cyl 1 -> 256
        t_mode("R7", 1'b1);
        do_load("R7", 7, 0, 3, 100);
        do_step("R7");
        do_load("R7", 9, 0, 9, 4095);
        do_step("R7");                       // wraps to 0
        t_mode("R7", 1'b0);                  // CHS address untouched -> 256
        t_prio();
        t_reset("R10");
        do_load("R10", 1, 1, 1, 0);          // native 4/17 -> 85
        do_dma("R10", 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule